// File: doc/BRIEF.md
# Register-mapped GPIO block with per-pin interrupts

This block is a general-purpose I/O peripheral behind an APB-style register interface. It serves up to four ports, each up to `PORT_W` pins wide. Every port has a software output value register and a direction register, whose contents drive the pin output and output-enable buses. Every port also has a read-only view of its pins, taken after a two-flop synchroniser.

The first port, port A, can also raise interrupts. For each pin, software picks level or edge sensing and picks the active polarity. It gates the pin with an enable bit and hides it with a mask bit. Edge events stay latched until software writes a one to the matching end-of-interrupt bit. Level events follow the pin. A port A pin can optionally pass through a debounce filter before detection. The filter accepts a new level only after the level has held for `DEB_TICKS` consecutive ticks of `db_tick`. All masked-in status bits are ORed onto one interrupt line.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are 0, and `irq_out` is 0.
- R2: Port p has its output value register at byte offset 12*p and its direction register at 12*p+4. The low `PORT_W` bits of a write are stored, read back, and appear on `pin_out` and `pin_oe` slice p in the cycle after the write. A direction bit of 1 means the pin is an output.
- R3: The pin values of port p read at offset 0x50+4*p, after two synchronising flops.
- R4: A port A pin whose type bit (0x38) is 0 is level sensed. A polarity bit (0x3C) of 1 means active high and 0 means active low. Its pending bit follows the pin, setting and clearing with it.
- R5: A port A pin whose type bit is 1 is edge sensed. A polarity bit of 1 selects the rising edge and 0 the falling edge. A detected edge stays pending after the pin returns to idle.
- R6: Writing 1 to a bit of the end-of-interrupt register (0x4C) clears that pin's latched edge; bits written 0 are untouched, and writing all ones clears every latched edge.
- R7: A mask bit (0x34) of 1 removes that pin from the status register (0x40) and from `irq_out`. The pending bit stays visible in the unmasked view at 0x44, and clearing the mask brings the pin back.
- R8: A pin whose enable bit (0x30) is 0 never becomes pending.
- R9: `irq_out` is 1 exactly when the status register is non-zero.
- R10: A port A pin whose debounce bit (0x48) is 1 is seen by the interrupt logic only after the new level holds for `DEB_TICKS` consecutive `db_tick` pulses. A shorter glitch raises nothing. With the bit at 0 the same glitch is detected.
- R11: Pins of ports B to D never cause interrupts. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write access |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from `paddr` |
| db_tick | input | 1 | Debounce sample strobe |
| pin_in | input | NUM_PORTS*PORT_W | Pin values, port A in the low bits |
| pin_out | output | NUM_PORTS*PORT_W | Output values |
| pin_oe | output | NUM_PORTS*PORT_W | Output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The detection logic is swept over every port A pin in all four type/polarity combinations. The pin moves idle, then active, then idle again. This separates level bits, which must drop with the pin, from edge bits, which must stay latched, and it shows whether the polarity picks the correct transition. Single-bit and all-ones end-of-interrupt writes show that clearing is per bit. A two-cycle glitch is applied with and without debounce, and then a long pulse with debounce. Together these tell a working filter from a missing or stuck one. Pins of the other ports are driven active with every port A interrupt enabled, to show they stay outside the interrupt path.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
    localparam logic [7:0] OFF_IRQ_EN   = 8'h30;
    localparam logic [7:0] OFF_IRQ_MASK = 8'h34;
    localparam logic [7:0] OFF_IRQ_KIND = 8'h38;
    localparam logic [7:0] OFF_IRQ_POL  = 8'h3C;
    localparam logic [7:0] OFF_STATUS   = 8'h40;
    localparam logic [7:0] OFF_RAW      = 8'h44;
    localparam logic [7:0] OFF_DEBOUNCE = 8'h48;
    localparam logic [7:0] OFF_EOI      = 8'h4C;
    localparam logic [7:0] OFF_EXT_BASE = 8'h50;
    localparam int         PORT_STRIDE  = 12;
    localparam int         MAX_PORTS    = 4;

    function automatic logic [7:0] data_off(input int p);
        return 8'(p * PORT_STRIDE);
    endfunction

    function automatic logic [7:0] dir_off(input int p);
        return 8'(p * PORT_STRIDE + 4);
    endfunction

    function automatic logic [7:0] ext_off(input int p);
        return 8'(32'(OFF_EXT_BASE) + p * 4);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_out = st_q.s2;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int W     = 8,
    parameter int TICKS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICKS - 1);

    typedef struct packed {
        logic [W-1:0][CNT_W-1:0] cnt;
        logic [W-1:0]            filt;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            for (int i = 0; i < W; i++) begin
                if (raw[i] == st_q.filt[i]) begin
                    st_d.cnt[i] = '0;
                end else if (st_q.cnt[i] == LIMIT) begin
                    st_d.filt[i] = raw[i];
                    st_d.cnt[i]  = '0;
                end else begin
                    st_d.cnt[i] = st_q.cnt[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clean = st_q.filt;
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] en,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] kind,
    input  logic [W-1:0] pol,
    input  logic         eoi_we,
    input  logic [W-1:0] eoi_bits,
    output logic [W-1:0] pend,
    output logic [W-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] pend;
    } irq_t;

    irq_t st_d, st_q;
    logic [W-1:0] rise, fall, edge_hit, lvl_hit, clr;

    always_comb begin
        rise     = src & ~st_q.prev;
        fall     = ~src & st_q.prev;
        edge_hit = (pol & rise) | (~pol & fall);
        lvl_hit  = ~(src ^ pol);
        clr      = eoi_we ? eoi_bits : '0;
        st_d      = st_q;
        st_d.prev = src;
        for (int i = 0; i < W; i++) begin
            if (kind[i]) st_d.pend[i] = en[i] & ((st_q.pend[i] & ~clr[i]) | edge_hit[i]);
            else         st_d.pend[i] = en[i] & lvl_hit[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend   = st_q.pend;
    assign status = st_q.pend & ~mask;
    assign irq    = |status;
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
    import gpio_apb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 32,
    parameter int DEB_TICKS = 4
) (
    input  logic                          pclk,
    input  logic                          presetn,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [7:0]                    paddr,
    input  logic [31:0]                   pwdata,
    output logic [31:0]                   prdata,
    input  logic                          db_tick,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_oe,
    output logic                          irq_out
);
    localparam int TOT_W = NUM_PORTS * PORT_W;

    typedef struct packed {
        logic [NUM_PORTS-1:0][PORT_W-1:0] dout;
        logic [NUM_PORTS-1:0][PORT_W-1:0] dir;
        logic [PORT_W-1:0]                en;
        logic [PORT_W-1:0]                mask;
        logic [PORT_W-1:0]                kind;
        logic [PORT_W-1:0]                pol;
        logic [PORT_W-1:0]                deb;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic              wr_en;
    logic              eoi_we;
    logic [PORT_W-1:0] wdat;
    logic [TOT_W-1:0]  pin_sync;
    logic [PORT_W-1:0] a_clean, a_src, a_pend, a_status;

    assign wr_en = psel & penable & pwrite;
    assign wdat  = pwdata[PORT_W-1:0];

    gpio_sync #(.W(TOT_W)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d_in  (pin_in),
        .q_out (pin_sync)
    );

    gpio_debounce #(.W(PORT_W), .TICKS(DEB_TICKS)) u_deb (
        .clk   (pclk),
        .rst_n (presetn),
        .tick  (db_tick),
        .raw   (pin_sync[PORT_W-1:0]),
        .clean (a_clean)
    );

    assign a_src = (regs_q.deb & a_clean) | (~regs_q.deb & pin_sync[PORT_W-1:0]);

    gpio_irq_core #(.W(PORT_W)) u_irq (
        .clk      (pclk),
        .rst_n    (presetn),
        .src      (a_src),
        .en       (regs_q.en),
        .mask     (regs_q.mask),
        .kind     (regs_q.kind),
        .pol      (regs_q.pol),
        .eoi_we   (eoi_we),
        .eoi_bits (wdat),
        .pend     (a_pend),
        .status   (a_status),
        .irq      (irq_out)
    );

    always_comb begin
        regs_d = regs_q;
        eoi_we = 1'b0;
        if (wr_en) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (paddr == data_off(p)) regs_d.dout[p] = wdat;
                if (paddr == dir_off(p))  regs_d.dir[p]  = wdat;
            end
            case (paddr)
                OFF_IRQ_EN:   regs_d.en   = wdat;
                OFF_IRQ_MASK: regs_d.mask = wdat;
                OFF_IRQ_KIND: regs_d.kind = wdat;
                OFF_IRQ_POL:  regs_d.pol  = wdat;
                OFF_DEBOUNCE: regs_d.deb  = wdat;
                OFF_EOI:      eoi_we      = 1'b1;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) regs_q <= '0;
        else          regs_q <= regs_d;
    end

    always_comb begin
        prdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (paddr == data_off(p)) prdata = 32'(regs_q.dout[p]);
            if (paddr == dir_off(p))  prdata = 32'(regs_q.dir[p]);
            if (paddr == ext_off(p))  prdata = 32'(pin_sync[p*PORT_W +: PORT_W]);
        end
        case (paddr)
            OFF_IRQ_EN:   prdata = 32'(regs_q.en);
            OFF_IRQ_MASK: prdata = 32'(regs_q.mask);
            OFF_IRQ_KIND: prdata = 32'(regs_q.kind);
            OFF_IRQ_POL:  prdata = 32'(regs_q.pol);
            OFF_STATUS:   prdata = 32'(a_status);
            OFF_RAW:      prdata = 32'(a_pend);
            OFF_DEBOUNCE: prdata = 32'(regs_q.deb);
            default:      ;
        endcase
    end

    assign pin_out = regs_q.dout;
    assign pin_oe  = regs_q.dir;
endmodule

// File: rtl/gpio_apb_ctrl_chk.sv
module gpio_apb_ctrl_chk #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 32
) (
    input logic                        pclk,
    input logic                        presetn,
    input logic                        wr_en,
    input logic [7:0]                  paddr,
    input logic [31:0]                 pwdata,
    input logic [NUM_PORTS*PORT_W-1:0] pin_out,
    input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0]           pend,
    input logic [PORT_W-1:0]           en,
    input logic [PORT_W-1:0]           mask,
    input logic [PORT_W-1:0]           kind,
    input logic                        irq_out
);
    // R2
    dout_wr_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && paddr == 8'h00) |=> (pin_out[PORT_W-1:0] == $past(pwdata[PORT_W-1:0])));

    // R2
    dir_wr_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && paddr == 8'h04) |=> (pin_oe[PORT_W-1:0] == $past(pwdata[PORT_W-1:0])));

    // R5
    edge_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !wr_en |=> (($past(pend & kind & en) & ~pend) == '0));

    // R8
    en_gate_chk: assert property (@(posedge pclk) disable iff (!presetn)
        presetn |=> ((pend & ~$past(en)) == '0));

    // R7
    mask_all_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (&mask) |-> !irq_out);
endmodule

bind gpio_apb_ctrl gpio_apb_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .wr_en   (wr_en),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pend    (a_pend),
    .en      (regs_q.en),
    .mask    (regs_q.mask),
    .kind    (regs_q.kind),
    .irq_out (irq_out)
);

// File: tb/gpio_apb_ctrl_bench.sv
module gpio_apb_ctrl_bench;
    localparam int NP = 4;
    localparam int W  = 8;

    logic        clk = 1'b0;
    logic        rstn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        db_tick = 1'b1;
    logic [NP*W-1:0] pins = '0;
    logic [NP*W-1:0] pout, poe;
    logic        irq;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    gpio_apb_ctrl #(.NUM_PORTS(NP), .PORT_W(W), .DEB_TICKS(4)) u_gpio_apb_ctrl (
        .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .db_tick(db_tick),
        .pin_in(pins), .pin_out(pout), .pin_oe(poe), .irq_out(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        wait_n(3);
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 oe", poe, 0);
        for (int a = 0; a < 'h60; a += 4) begin
            rd(8'(a), v);
            check("R1 regs", v, 0);
        end
        rstn = 1'b1;
        wait_n(2);

        // R2 data and direction per port
        for (int p = 0; p < NP; p++) begin
            wr(8'(12 * p), 32'(8'h11 * (p + 1)));
            wr(8'(12 * p + 4), 32'(~(8'h11 * (p + 1))));
        end
        for (int p = 0; p < NP; p++) begin
            rd(8'(12 * p), v);
            check("R2 data rd", v, 32'(8'h11 * (p + 1)));
            rd(8'(12 * p + 4), v);
            check("R2 dir rd", v, 32'(8'(~(8'h11 * (p + 1)))));
            check("R2 pin_out", 32'(pout[p*W +: W]), 32'(8'h11 * (p + 1)));
            check("R2 pin_oe", 32'(poe[p*W +: W]), 32'(8'(~(8'h11 * (p + 1)))));
        end

        // R3 synchronised pin read
        pins = 32'hA55A3CC3;
        wait_n(4);
        for (int p = 0; p < NP; p++) begin
            rd(8'(8'h50 + 4 * p), v);
            check("R3 ext", v, 32'(pins[p*W +: W]));
        end
        pins = '0;
        wait_n(4);

        // R4 R5 R6 R8 R9 sweep over every port A pin and mode
        for (int i = 0; i < W; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic ed, pl;
                ed = m[1]; pl = m[0];
                wr(8'h30, 0);
                pins = '0;
                wr(8'h38, ed ? 32'(1 << i) : 0);
                wr(8'h3C, pl ? 32'(1 << i) : 0);
                pins[i] = ~pl;
                wait_n(5);
                rd(8'h44, v);
                check("R8 disabled raw", v, 0);
                wr(8'h30, 32'(1 << i));
                wr(8'h4C, 32'hFF);
                wait_n(2);
                rd(8'h40, v);
                check("R4/R5 idle status", v, 0);
                pins[i] = pl;
                wait_n(5);
                rd(8'h40, v);
                check(ed ? "R5 edge hit" : "R4 level hit", v, 32'(1 << i));
                check("R9 irq set", {31'b0, irq}, 1);
                pins[i] = ~pl;
                wait_n(5);
                rd(8'h40, v);
                check(ed ? "R5 edge held" : "R4 level drop", v, ed ? 32'(1 << i) : 0);
                if (ed) begin
                    wr(8'h4C, 32'(1 << i));
                    rd(8'h40, v);
                    check("R6 eoi bit", v, 0);
                    check("R9 irq clear", {31'b0, irq}, 0);
                end
            end
        end

        // R6 all-ones clear, R6 per-bit selectivity
        wr(8'h30, 0);
        pins = '0;
        wr(8'h38, 32'hFF);
        wr(8'h3C, 32'hFF);
        wr(8'h30, 32'h0F);
        wait_n(3);
        pins[3:0] = 4'hF;
        wait_n(4);
        pins[3:0] = 4'h0;
        wait_n(4);
        rd(8'h40, v);
        check("R6 multi pending", v, 32'h0F);
        wr(8'h4C, 32'h05);
        rd(8'h40, v);
        check("R6 partial eoi", v, 32'h0A);
        wr(8'h4C, 32'hFFFFFFFF);
        rd(8'h40, v);
        check("R6 all eoi", v, 0);

        // R7 mask
        wr(8'h30, 0);
        wr(8'h38, 0);
        wr(8'h3C, 32'h01);
        wr(8'h34, 32'h01);
        wr(8'h30, 32'h01);
        pins[0] = 1'b1;
        wait_n(5);
        rd(8'h40, v);
        check("R7 masked status", v, 0);
        check("R7 masked irq", {31'b0, irq}, 0);
        rd(8'h44, v);
        check("R7 raw view", v, 32'h01);
        wr(8'h34, 0);
        rd(8'h40, v);
        check("R7 unmasked", v, 32'h01);
        // R11 status write ignored
        wr(8'h40, 32'h0);
        rd(8'h40, v);
        check("R11 status ro", v, 32'h01);
        pins[0] = 1'b0;
        wait_n(4);

        // R11 other ports do not interrupt
        wr(8'h30, 32'hFF);
        wr(8'h3C, 32'hFF);
        pins[31:8] = '1;
        wait_n(6);
        rd(8'h40, v);
        check("R11 status", v, 0);
        check("R11 irq", {31'b0, irq}, 0);
        pins = '0;
        wr(8'h30, 0);

        // R10 debounce
        wr(8'h38, 32'h02);
        wr(8'h3C, 32'h02);
        wr(8'h48, 32'h02);
        wr(8'h30, 32'h02);
        wait_n(6);
        wr(8'h4C, 32'hFF);
        pins[1] = 1'b1; wait_n(2); pins[1] = 1'b0;
        wait_n(12);
        rd(8'h40, v);
        check("R10 glitch filtered", v, 0);
        wr(8'h48, 0);
        pins[1] = 1'b1; wait_n(2); pins[1] = 1'b0;
        wait_n(8);
        rd(8'h40, v);
        check("R10 glitch unfiltered", v, 32'h02);
        wr(8'h4C, 32'hFF);
        wr(8'h48, 32'h02);
        wait_n(4);
        pins[1] = 1'b1; wait_n(8); pins[1] = 1'b0;
        wait_n(12);
        rd(8'h40, v);
        check("R10 long pulse", v, 32'h02);
        rd(8'h48, v);
        check("R10 reg rd", v, 32'h02);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule